// File: doc/BRIEF.md
# Select-Framed SPI Target Byte Engine

This block is the target side of an SPI link. It exchanges a stream of whole bytes in both directions during one transfer, and the active-low select line alone marks the start and the end of that transfer. Any number of bytes may pass back to back while select stays low.

The serial clock may rest high or low between transfers, and the block handles both cases without any configuration input. The block samples the incoming data bit on each rising clock edge. It moves the outgoing data bit on falling clock edges, and only on those that follow a rising edge within the frame. Both directions go most significant bit first.

The serial clock, the select line and the incoming data line are resynchronised and oversampled by a system clock that runs at least six times faster than the serial clock. Toward the user, each received byte appears with a one-cycle strobe. A transmit request strobe asks for the next outgoing byte, which the user writes through a data bus and load strobe. The user writes the first byte before select falls. The output data line has its own enable, so the pin is released to high impedance whenever select is high, and other targets can share the bus.

Top module: `spi_frame_target`

## Requirements
- R1: `miso_oe_o` is 0 whenever `spi_ss_n_i` is 1 and is 1 whenever `spi_ss_n_i` is 0, with no system-clock delay, so the line is released to high impedance while select is high.
- R2: A byte loaded while select is high drives its bit 7 on `miso_o` as soon as select falls, before any serial clock edge.
- R3: Incoming bits are taken on rising `spi_sclk_i` edges, first bit as bit 7. After the eighth rise of a byte, `rx_valid_o` pulses for exactly one cycle with the byte on `rx_data_o`, and `rx_data_o` holds its value in every cycle without the strobe.
- R4: The outgoing byte is shifted out bit 7 first. `miso_o` advances one bit on each falling `spi_sclk_i` edge that follows a rising edge in the same frame.
- R5: With the serial clock idling high (mode 3), the first falling edge after select falls does not shift `miso_o`. Mode 0 and mode 3 transfers both give correct data in both directions with no mode input.
- R6: `tx_req_o` pulses once for each completed byte. A byte loaded after that pulse and before the next falling clock edge is the next byte sent in the same frame, so several bytes run back to back.
- R7: If select rises with a partial byte received, no `rx_valid_o` pulse is given for it and `frame_abort_o` pulses for exactly one cycle. The next frame starts again at bit 7.
- R8: If select rises right after a whole number of bytes, `frame_abort_o` stays 0.
- R9: During and just after reset, `rx_valid_o`, `tx_req_o` and `frame_abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least six times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from the controller |
| spi_ss_n_i | input | 1 | Active-low select framing the transfer |
| spi_mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Output enable for the data pin; 0 means high impedance |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| tx_data_i | input | DATA_W | Next byte to send |
| tx_load_i | input | 1 | Writes `tx_data_i` into the transmit holding register |
| tx_req_o | output | 1 | One-cycle request for the next transmit byte |
| frame_abort_o | output | 1 | One-cycle pulse when select ends a frame mid-byte |

## Verification
Two cases are hard to reach from the ports. The first is a frame with the clock resting high, where the first falling edge must leave the output bit alone. The bench covers it by starting a frame with the serial clock high and then checking that the first sampled bit is still bit 7 of the preloaded byte. The second is select rising partway through a byte. Here the bench sends eleven clock edges, expects exactly one received byte and one abort pulse, and then runs a clean frame to show that the bit position was reset. The follow-on bytes are fed only when `tx_req_o` asks for them, so the handover at each byte boundary is tested under the real timing, not preloaded.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    // Raw serial pins as seen at the block boundary
    typedef struct packed {
        logic sclk;
        logic ss_n;
        logic mosi;
    } pin_set_t;

    // Resting level assumed for the pins at reset
    localparam pin_set_t PIN_IDLE = '{sclk: 1'b0, ss_n: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync
    import spi_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_set_t raw_i,
    output logic     sclk_rise_o,
    output logic     sclk_fall_o,
    output logic     ss_rise_o,
    output logic     ss_active_o,
    output logic     mosi_o
);

    typedef struct packed {
        pin_set_t [STAGES-1:0] chain;
        pin_set_t              last;
    } sync_st_t;

    sync_st_t st_d, st_q;
    pin_set_t cur, prev;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.last = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{PIN_IDLE}};
            st_q.last  <= PIN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur  = st_q.chain[STAGES-1];
    assign prev = st_q.last;

    assign sclk_rise_o = cur.sclk & ~prev.sclk;
    assign sclk_fall_o = ~cur.sclk & prev.sclk;
    assign ss_rise_o   = cur.ss_n & ~prev.ss_n;
    assign ss_active_o = ~cur.ss_n;
    assign mosi_o      = cur.mosi;

endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_active_i,
    input  logic              ss_rise_i,
    input  logic              sclk_rise_i,
    input  logic              mosi_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              abort_o,
    output logic              armed_o,
    output logic              at_boundary_o
);

    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              armed;
        logic              abort;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [DATA_W-1:0] shifted;

    assign shifted = {st_q.sh[DATA_W-2:0], mosi_i};

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.abort = 1'b0;
        if (!ss_active_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
            if (ss_rise_i && (st_q.cnt != '0)) begin
                st_d.abort = 1'b1;
            end
        end else if (sclk_rise_i) begin
            st_d.armed = 1'b1;
            st_d.sh    = shifted;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt   = '0;
                st_d.data  = shifted;
                st_d.valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data_o     = st_q.data;
    assign rx_valid_o    = st_q.valid;
    assign abort_o       = st_q.abort;
    assign armed_o       = st_q.armed;
    assign at_boundary_o = (st_q.cnt == '0);

endmodule

// File: rtl/spi_tgt_tx.sv
module spi_tgt_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_active_i,
    input  logic              sclk_fall_i,
    input  logic              armed_i,
    input  logic              at_boundary_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              miso_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] sh;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [DATA_W-1:0] fresh;

    // A byte written in this very cycle takes the place of the held one
    assign fresh = tx_load_i ? tx_data_i : st_q.hold;

    always_comb begin
        st_d = st_q;
        if (tx_load_i) begin
            st_d.hold = tx_data_i;
        end
        if (!ss_active_i) begin
            st_d.sh = fresh;
        end else if (sclk_fall_i && armed_i) begin
            if (at_boundary_i) begin
                st_d.sh = fresh;
            end else begin
                st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o = st_q.sh[DATA_W-1];

endmodule

// File: rtl/spi_frame_target.sv
module spi_frame_target
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk_i,
    input  logic              spi_ss_n_i,
    input  logic              spi_mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              tx_req_o,
    output logic              frame_abort_o
);

    pin_set_t raw;
    logic sclk_rise, sclk_fall, ss_rise, ss_active, mosi_s;
    logic armed, at_boundary;

    assign raw = '{sclk: spi_sclk_i, ss_n: spi_ss_n_i, mosi: spi_mosi_i};

    spi_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_i       (raw),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .ss_rise_o   (ss_rise),
        .ss_active_o (ss_active),
        .mosi_o      (mosi_s)
    );

    spi_tgt_rx #(.DATA_W(DATA_W)) rx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ss_active_i   (ss_active),
        .ss_rise_i     (ss_rise),
        .sclk_rise_i   (sclk_rise),
        .mosi_i        (mosi_s),
        .rx_data_o     (rx_data_o),
        .rx_valid_o    (rx_valid_o),
        .abort_o       (frame_abort_o),
        .armed_o       (armed),
        .at_boundary_o (at_boundary)
    );

    spi_tgt_tx #(.DATA_W(DATA_W)) tx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ss_active_i   (ss_active),
        .sclk_fall_i   (sclk_fall),
        .armed_i       (armed),
        .at_boundary_i (at_boundary),
        .tx_data_i     (tx_data_i),
        .tx_load_i     (tx_load_i),
        .miso_o        (miso_o)
    );

    // Each completed byte is also the cue for the next transmit byte
    assign tx_req_o = rx_valid_o;

    // Enable follows the pin directly to meet the release budget
    assign miso_oe_o = ~spi_ss_n_i;

endmodule

// File: rtl/spi_frame_target_chk.sv
module spi_frame_target_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_ss_n_i,
    input logic              miso_oe_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_valid_o,
    input logic              frame_abort_o
);

    assert_released_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ss_n_i |-> !miso_oe_o);

    assert_rx_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_rx_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> $stable(rx_data_o));

    assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort_o |=> !frame_abort_o);

    assert_abort_without_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort_o |-> !rx_valid_o);

endmodule

bind spi_frame_target spi_frame_target_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/spi_frame_target_tb_top.sv
module spi_frame_target_tb_top;

    localparam int W    = 8;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         ss_n = 1'b1;
    logic         mosi = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_load = 1'b0;
    logic         miso_o, miso_oe_o, rx_valid_o, tx_req_o, frame_abort_o;
    logic [W-1:0] rx_data_o;

    int  checks = 0;
    int  errors = 0;
    int  abort_seen = 0;
    int  req_seen = 0;
    bit  pre_req = 1'b0;
    bit  done = 1'b0;

    logic [W-1:0] exp_rx[$];
    logic [W-1:0] tx_next[$];

    always #2 clk = ~clk;

    spi_frame_target #(.DATA_W(W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_sclk_i    (sclk),
        .spi_ss_n_i    (ss_n),
        .spi_mosi_i    (mosi),
        .miso_o        (miso_o),
        .miso_oe_o     (miso_oe_o),
        .rx_data_o     (rx_data_o),
        .rx_valid_o    (rx_valid_o),
        .tx_data_i     (tx_data),
        .tx_load_i     (tx_load),
        .tx_req_o      (tx_req_o),
        .frame_abort_o (frame_abort_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design delivers them
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rx_valid_o) begin
                    if (exp_rx.size() == 0) begin
                        check(1'b0, "R7", "rx strobe with nothing expected", rx_data_o, 0);
                    end else begin
                        logic [W-1:0] e;
                        e = exp_rx.pop_front();
                        check(rx_data_o == e, "R3", "received byte", rx_data_o, e);
                    end
                end
                if (tx_req_o) req_seen++;
                if (frame_abort_o) abort_seen++;
            end
        end
    end

    // Responder: feeds the next transmit byte on request or preload
    initial begin
        forever begin
            @(negedge clk);
            tx_load = 1'b0;
            if ((tx_req_o || pre_req) && tx_next.size() > 0) begin
                tx_data = tx_next.pop_front();
                tx_load = 1'b1;
            end
        end
    end

    task automatic run_frame(input bit cpol, input logic [W-1:0] txb[],
                             input logic [W-1:0] rxb[], input int nbits,
                             input int exp_abort, input string tag);
        int abort_base, req_base;
        logic [W-1:0] got;
        sclk = cpol;
        tx_next.delete();
        tx_next.push_back(txb[0]);
        @(posedge clk); pre_req = 1'b1;
        @(posedge clk); pre_req = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 1; i < txb.size(); i++) tx_next.push_back(txb[i]);
        for (int i = 0; i < nbits / W; i++) exp_rx.push_back(rxb[i]);
        abort_base = abort_seen;
        req_base   = req_seen;
        got        = '0;

        @(negedge clk); ss_n = 1'b0;
        @(negedge clk);
        check(miso_oe_o == 1'b1, "R1", {tag, " enable after select low"}, miso_oe_o, 1);
        check(miso_o == txb[0][W-1], "R2", {tag, " first bit before clock"}, miso_o, txb[0][W-1]);
        repeat (5) @(negedge clk);

        for (int b = 0; b < nbits; b++) begin
            sclk = 1'b0;
            mosi = rxb[b / W][W - 1 - (b % W)];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            got[W - 1 - (b % W)] = miso_o;
            if ((b % W) == W - 1) begin
                check(got == txb[b / W], cpol ? "R5" : "R4",
                      {tag, " transmitted byte"}, got, txb[b / W]);
            end
            repeat (HALF) @(negedge clk);
        end
        if (!cpol) begin
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end

        ss_n = 1'b1;
        @(negedge clk);
        check(miso_oe_o == 1'b0, "R1", {tag, " released after select high"}, miso_oe_o, 0);
        repeat (8) @(negedge clk);
        check(abort_seen - abort_base == exp_abort, exp_abort ? "R7" : "R8",
              {tag, " abort pulses"}, abort_seen - abort_base, exp_abort);
        check(req_seen - req_base == nbits / W, "R6", {tag, " request pulses"},
              req_seen - req_base, nbits / W);
        check(exp_rx.size() == 0, "R6", {tag, " bytes still awaited"}, exp_rx.size(), 0);
        repeat (6) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_valid_o == 1'b0, "R9", "rx strobe in reset", rx_valid_o, 0);
        check(tx_req_o == 1'b0, "R9", "request in reset", tx_req_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(frame_abort_o == 1'b0, "R9", "abort after reset", frame_abort_o, 0);
        check(miso_oe_o == 1'b0, "R1", "enable idle after reset", miso_oe_o, 0);

        // Mode 0, three bytes back to back
        run_frame(1'b0, '{8'hA5, 8'h3C, 8'hF0}, '{8'h5A, 8'hC3, 8'h0F}, 24, 0, "mode0");
        // Mode 3, two bytes: first falling edge must not shift
        run_frame(1'b1, '{8'h81, 8'h7E}, '{8'h96, 8'h69}, 16, 0, "mode3");
        // Select rises after eleven bits: one byte, one abort
        run_frame(1'b0, '{8'h11, 8'h22}, '{8'hE7, 8'h18}, 11, 1, "abort");
        // Clean frame right after the abort starts again at bit 7
        run_frame(1'b0, '{8'hC9, 8'h36}, '{8'h2D, 8'hD2}, 16, 0, "recover");
        // Single byte in mode 3 with extreme patterns, ends on a boundary
        run_frame(1'b1, '{8'h00}, '{8'hFF}, 8, 0, "boundary");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule